// File: doc/BRIEF.md
# Interleaved Four-Bank Line Refill Memory

This block is the memory side of a cache-line refill path. A line of four words is spread over four one-word-wide DRAM banks, with consecutive words in consecutive banks. When a requester hands over a line address, the block spends one bus cycle on the address phase and then starts all four banks together. The shared access time therefore overlaps for the whole line. The four words then come back one per bus cycle over a single word-wide data bus, each marked with a valid strobe, and the fourth word also carries a last flag. A full line costs 1 + 15 + 4 = 20 bus cycles. A single narrow bank would need 65 cycles for the same line.

The bank contents sit in plain internal storage. A word write port loads that storage, and it uses the same interleaved mapping as the refill path. A controller state machine sequences the refill through four states:

- `S_IDLE`: ready for a request.
- `S_ADDR`: the one-cycle address phase. At its end all banks are started.
- `S_ACCESS`: the controller waits until every bank reports its word captured.
- `S_XFER`: four beats, one word per bank in bank order.

The state machine has five transitions:

- `S_IDLE` to `S_ADDR` on an accepted request.
- `S_ADDR` to `S_ACCESS` unconditionally.
- `S_ACCESS` to `S_XFER` when every bank is ready.
- `S_XFER` to itself on beats 0 to 2.
- `S_XFER` to `S_IDLE` on beat 3.

A one-cycle done pulse follows the last word.

Top module: `ilv_refill_mem`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_valid`, `rd_last` and `done` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the last word has been transferred.
- R3: Call the first clock period after the accepting edge cycle 1. Cycle 1 is the address phase and cycles 2 to 16 are the 15-cycle bank access, so the first word appears with `rd_valid` in cycle 17.
- R4: Every accepted line produces exactly four consecutive `rd_valid` cycles, in cycles 17, 18, 19 and 20.
- R5: Word k (k = 0..3) of line L is the word stored at word address 4·L + k. That is, bank k holds it, at in-bank row L.
- R6: `rd_last` is 1 only together with the fourth word. It appears in cycle 20, so a line costs exactly 20 cycles from acceptance to its last word.
- R7: `done` is a single-cycle pulse in cycle 21, the cycle right after the last word. `req_ready` is 1 in that same cycle, so a new request can be taken at the end of cycle 21.
- R8: `req_valid` asserted while a line is in progress is ignored. No extra words and no extra line follow.
- R9: A write with `wr_en` = 1 stores `wr_data` at word address `wr_addr`. Bits [1:0] select the bank and the upper bits select the row, so a later refill of that line returns the new value.
- R10: The line address is taken from `req_line` only at the accepting edge. Changing `req_line` afterwards does not alter the words returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line refill request |
| req_ready | output | 1 | Block can accept a request |
| req_line | input | LINE_W (6) | Line address (in-bank row) |
| wr_en | input | 1 | Word write strobe for the bank storage |
| wr_addr | input | LINE_W+2 (8) | Word address of the write |
| wr_data | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | A refill word is on `rd_data` |
| rd_data | output | DATA_W (32) | Refill word |
| rd_last | output | 1 | Marks the fourth word of the line |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
Three kinds of internal fault show up at the ports within one line, at most 21 cycles after the request.

- A wrong access count, or a controller that leaves the access state before every bank is ready, moves the first `rd_valid` away from cycle 17.
- A fault in the bank select or the beat counter puts a word from the wrong bank or row on `rd_data`, and the word-by-word comparison against the written pattern catches it.
- A state machine that fails to return to idle, or returns too early, shows as `req_ready` high during a line, a misplaced `done`, or words arriving with no request outstanding.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned BANKS      = 4;
    localparam int unsigned BANK_SEL_W = $clog2(BANKS);

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_ACCESS,
        S_XFER
    } ilv_state_t;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ROW_W   = 6,
    parameter int unsigned ACC_CYC = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              data_ok,
    output logic [DATA_W-1:0] dout
);

    localparam int unsigned DEPTH = 1 << ROW_W;
    localparam int unsigned CNT_W = $clog2(ACC_CYC + 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [ROW_W-1:0]  row_q;
    logic [CNT_W-1:0]  cnt;
    logic              busy;

    // storage write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_row] <= wr_data;
        end
    end

    // access timer: start seen at end of address phase, word captured
    // so that data_ok is high in the last access cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            cnt     <= '0;
            busy    <= 1'b0;
            data_ok <= 1'b0;
            dout    <= '0;
        end else if (start) begin
            row_q   <= rd_row;
            cnt     <= CNT_W'(ACC_CYC - 2);
            busy    <= 1'b1;
            data_ok <= 1'b0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy    <= 1'b0;
                data_ok <= 1'b1;
                dout    <= store[row_q];
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int unsigned LINE_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [LINE_W-1:0]     req_line,
    input  logic                  all_ok,
    output logic                  req_ready,
    output logic [LINE_W-1:0]     line_q,
    output logic                  bank_start,
    output logic [BANK_SEL_W-1:0] beat,
    output logic                  rd_valid,
    output logic                  rd_last,
    output logic                  done
);

    localparam logic [BANK_SEL_W-1:0] LAST_BEAT = BANK_SEL_W'(BANKS - 1);

    ilv_state_t state, state_nx;
    logic       accept;
    logic       last_beat;

    assign accept    = req_valid && (state == S_IDLE);
    assign last_beat = (state == S_XFER) && (beat == LAST_BEAT);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_ADDR;
            S_ADDR:   state_nx = S_ACCESS;
            S_ACCESS: if (all_ok) state_nx = S_XFER;
            S_XFER:   if (beat == LAST_BEAT) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register and the registers that ride with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            beat   <= '0;
            line_q <= '0;
            done   <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= last_beat;
            if (accept) begin
                line_q <= req_line;
            end
            if (state == S_XFER) begin
                beat <= beat + 1'b1;
            end else begin
                beat <= '0;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready  = 1'b0;
        bank_start = 1'b0;
        rd_valid   = 1'b0;
        rd_last    = 1'b0;
        unique case (state)
            S_IDLE:   req_ready  = 1'b1;
            S_ADDR:   bank_start = 1'b1;
            S_ACCESS: ;
            S_XFER: begin
                rd_valid = 1'b1;
                rd_last  = (beat == LAST_BEAT);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ilv_refill_mem.sv
module ilv_refill_mem
    import ilv_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned LINE_W  = 6,
    parameter int unsigned ACC_CYC = 15,
    localparam int unsigned WADDR_W = LINE_W + BANK_SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [LINE_W-1:0]  req_line,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_last,
    output logic               done
);

    logic [LINE_W-1:0]     line_q;
    logic                  bank_start;
    logic [BANK_SEL_W-1:0] beat;
    logic [BANKS-1:0]      bank_ok;
    logic [DATA_W-1:0]     bank_dout [BANKS];
    logic                  all_ok;

    assign all_ok = &bank_ok;

    ilv_ctrl #(.LINE_W(LINE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_line   (req_line),
        .all_ok     (all_ok),
        .req_ready  (req_ready),
        .line_q     (line_q),
        .bank_start (bank_start),
        .beat       (beat),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .done       (done)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic sel_wr;
        assign sel_wr = wr_en && (wr_addr[BANK_SEL_W-1:0] == BANK_SEL_W'(b));

        ilv_bank #(
            .DATA_W  (DATA_W),
            .ROW_W   (LINE_W),
            .ACC_CYC (ACC_CYC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_wr),
            .wr_row  (wr_addr[WADDR_W-1:BANK_SEL_W]),
            .wr_data (wr_data),
            .start   (bank_start),
            .rd_row  (line_q),
            .data_ok (bank_ok[b]),
            .dout    (bank_dout[b])
        );
    end

    assign rd_data = bank_dout[beat];

endmodule

// File: rtl/ilv_refill_chk.sv
module ilv_refill_chk #(
    parameter int unsigned ACC_CYC = 15
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic rd_last,
    input logic done
);

    logic [15:0] since_acc;
    logic [2:0]  vcount;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_acc <= '0;
            vcount    <= '0;
        end else if (req_valid && req_ready) begin
            since_acc <= 16'd1;
            vcount    <= '0;
        end else begin
            if (since_acc != '0 && since_acc != 16'hFFFF) since_acc <= since_acc + 1'b1;
            if (rd_valid && vcount != 3'd7) vcount <= vcount + 1'b1;
        end
    end

    // R3
    first_word_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (32'(since_acc) == 32'(ACC_CYC + 2)));

    // R6
    last_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> (rd_valid && 32'(since_acc) == 32'(ACC_CYC + 5)));

    // R4
    beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> (vcount == 3'd3));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);

    // R7
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> (done && req_ready));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind ilv_refill_mem ilv_refill_chk #(.ACC_CYC(ACC_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_last   (rd_last),
    .done      (done)
);

// File: tb/sim_ilv_refill_mem.sv
module sim_ilv_refill_mem;

    localparam int DW  = 32;
    localparam int LW  = 6;
    localparam int AW  = LW + 2;
    localparam int NW  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [LW-1:0] req_line = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_last;
    logic          done;

    int checks = 0;
    int errors = 0;
    int cyc = 1000;
    logic [DW-1:0] model [NW];
    logic [DW-1:0] exp_data [$];
    int            exp_idx  [$];

    always #10 clk = ~clk;

    ilv_refill_mem u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_line(req_line), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h cyc=%0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return 32'h5A00_0000 ^ (32'(a) << 12) ^ (32'(a) * 32'h0001_0203) ^ 32'(salt);
    endfunction

    task automatic wr_word(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model[a] = d;
    endtask

    // driver: pushes the four expected words then issues the request
    task automatic refill(input int line, input bit hold_busy);
        do @(negedge clk); while (!(req_ready && exp_data.size() == 0));
        for (int k = 0; k < 4; k++) begin
            exp_data.push_back(model[line*4 + k]);
            exp_idx.push_back(k);
        end
        req_line  = LW'(line);
        req_valid = 1'b1;
        @(posedge clk);
        cyc = 0;
        #1;
        req_line = LW'(line) ^ 6'h2A; // R10: changed after acceptance
        if (hold_busy) begin
            repeat (19) @(posedge clk); // R8: request held during the line
            #1;
        end
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (rd_valid) begin
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R8 unexpected word", rd_data, '0);
                end else begin
                    logic [DW-1:0] d;
                    int k;
                    d = exp_data.pop_front();
                    k = exp_idx.pop_front();
                    chk(rd_data == d, "R5 data", rd_data, d);
                    chk(rd_last == (k == 3), "R6 last flag", DW'(rd_last), DW'(k == 3));
                    chk(cyc == 17 + k, "R3 R4 beat timing", DW'(cyc), DW'(17 + k));
                end
            end else if (cyc >= 17 && cyc <= 20) begin
                chk(1'b0, "R4 missing beat", DW'(cyc), '0);
            end
            if (cyc >= 1 && cyc <= 20) begin
                chk(!req_ready, "R2 ready low while busy", DW'(req_ready), '0);
            end
            if (done) begin
                chk(cyc == 21, "R7 done timing", DW'(cyc), 32'd21);
                chk(req_ready, "R7 ready with done", DW'(req_ready), 32'd1);
            end
            if (cyc == 21) begin
                chk(done, "R7 done missing", DW'(done), 32'd1);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready, "R1 ready", DW'(req_ready), 32'd1);
        chk(!rd_valid, "R1 rd_valid", DW'(rd_valid), '0);
        chk(!rd_last, "R1 rd_last", DW'(rd_last), '0);
        chk(!done, "R1 done", DW'(done), '0);

        // R9 fill every bank through the interleaved write port
        for (int a = 0; a < NW; a++) wr_word(a, pat(a, 0));

        refill(0, 1'b0);
        refill(1, 1'b0);
        refill(63, 1'b0);          // top row boundary
        refill(5, 1'b1);           // R8 and R10
        refill(2, 1'b0);           // back-to-back
        refill(3, 1'b0);

        // R9 overwrite one word in bank 2 and one in bank 0, then reread
        wr_word(7*4 + 2, 32'hDEAD_BEEF);
        wr_word(7*4 + 0, 32'h0BAD_F00D);
        refill(7, 1'b0);
        refill(6, 1'b0);           // neighbour line untouched

        do @(negedge clk); while (!(req_ready && exp_data.size() == 0));
        repeat (5) @(negedge clk);
        chk(!rd_valid, "R8 quiet after last line", DW'(rd_valid), '0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule